// File: doc/BRIEF.md
# Fast Blank Input Conditioner

This block takes the single-bit fast-blank overlay signal, which arrives asynchronously and is sampled in the pixel clock domain, and turns it into a clean, aligned select signal for the video mixer. The raw pin first passes a two-flop synchronizer. A programmable sense bit then sets whether the input is active high or active low. The conditioned level is then delayed by a whole number of clock cycles, so that the overlay switch lands on the same pixel as the video paths it selects between.

A four-bit fine trim value describes the wanted delay in eighths of a clock. Its top bit adds one more whole cycle to the delay line. Its lower three bits are passed out unchanged as a sub-cycle phase for a downstream interpolator.

The host sees a small register port with a write strobe, a read strobe, an address and a registered read-data bus. Address 0 returns a status nibble. Three of its bits are sticky flags (rising edge seen, falling edge seen, level seen high) and one is the live level. Reading address 0 clears the sticky flags. An event that coincides with the clearing read is kept for the next read.

Top module: `fblank_cond`

## Requirements
- R1: After a synchronous active-low reset, the whole-cycle delay reads 4, the trim reads 4, `phase_out` is 4, the sense bit is 0, all sticky flags are clear and `fb_out` is 0.
- R2: Sense bit (address 0, write data bit 3): at 0 the conditioned level equals the pin; at 1 it is the inverted pin.
- R3: `fb_out` equals the conditioned pin value delayed by 3 + D + T[3] clock edges, where D is the whole-cycle delay (address 1, bits 3:0) and T is the trim (address 2, bits 3:0).
- R4: A read of address 1 returns the delay in bits 3:0. A read of address 2 returns the trim in bits 3:0. Upper bits read 0. `rd_data` is valid on the clock edge that samples `rd_en`.
- R5: Status bit 0 (read data bit 4) is set by a 0-to-1 change of the conditioned level and stays set until a read of address 0.
- R6: Status bit 1 (read data bit 5) is set by a 1-to-0 change of the conditioned level and stays set until a read of address 0.
- R7: Status bit 2 (read data bit 6) is the conditioned level at the cycle of the read.
- R8: Status bit 3 (read data bit 7) is set whenever the conditioned level is 1 and stays set until a read of address 0.
- R9: A read of address 0 clears all sticky flags. Reads of other addresses leave them unchanged.
- R10: A read of address 0 returns the flag values from before the clear. An event in the same cycle as that read leaves its flag set afterwards.
- R11: `phase_out` equals trim bits 2:0 from the clock edge after the trim write.
- R12: The sense bit is write-only. Read data bits 3:0 of address 0 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_pin | input | 1 | Raw asynchronous fast-blank input |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0 control/status, 1 delay, 2 trim) |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Registered read data |
| fb_out | output | 1 | Conditioned and aligned fast-blank output |
| phase_out | output | 3 | Sub-cycle phase for a downstream interpolator |

## Verification
A pin change reaches `fb_out` after exactly 3 + D + T[3] rising edges. The bench keeps a per-edge history of the pin it drove and compares every sampled output against the entry that many edges back. It checks only once the delay settings have been stable for longer than the deepest window. Read data is registered, so each read result is sampled half a cycle after the edge that accepted the strobe. A status flag lags the pin by two synchronizer edges plus one flag edge. The coincident-event case is placed so that the flag's capturing edge and the clearing read fall on the same edge. The bench then expects the earlier flag value on that read and the set flag on the next read.

// File: rtl/fbc_pkg.sv
// Package: shared constants and the status type for the fast-blank conditioner.
// Assumes an 8-bit register data path and a 2-bit address space.
package fbc_pkg;
    localparam int unsigned FBC_DW       = 8;
    localparam int unsigned FBC_AW       = 2;
    localparam logic [FBC_AW-1:0] ADR_CTRL = 2'd0;
    localparam logic [FBC_AW-1:0] ADR_DLY  = 2'd1;
    localparam logic [FBC_AW-1:0] ADR_TRIM = 2'd2;
    localparam int unsigned SENSE_BIT    = 3;
    localparam int unsigned STAT_LSB     = 4;

    // Status nibble; bit 0 is rise, bit 3 is seen-high.
    typedef struct packed {
        logic seen_high;
        logic live;
        logic fell;
        logic rose;
    } fbc_stat_t;
endpackage

// File: rtl/fbc_sync.sv
// Module: multi-flop synchronizer for one asynchronous bit.
// Assumes STAGES >= 2; output resets low.
module fbc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fbc_status.sv
// Module: edge detection and sticky status flags with clear-on-read.
// Assumes 'lvl' is already synchronous and polarity-corrected.
// A clear and a simultaneous event leave the flag set.
module fbc_status
    import fbc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl,
    input  logic      clr,
    output fbc_stat_t stat,
    output logic      rise_evt
);
    logic lvl_q;
    logic fall_evt;
    logic rose_q, fell_q, high_q;

    assign rise_evt = lvl & ~lvl_q;
    assign fall_evt = ~lvl & lvl_q;

    // Remember the previous level and update sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            rose_q <= 1'b0;
            fell_q <= 1'b0;
            high_q <= 1'b0;
        end else begin
            lvl_q  <= lvl;
            rose_q <= (rose_q & ~clr) | rise_evt;
            fell_q <= (fell_q & ~clr) | fall_evt;
            high_q <= (high_q & ~clr) | lvl;
        end
    end

    // Assemble the readable status nibble.
    always_comb begin
        stat.rose      = rose_q;
        stat.fell      = fell_q;
        stat.live      = lvl;
        stat.seen_high = high_q;
    end
endmodule

// File: rtl/fbc_delay.sv
// Module: programmable whole-cycle delay line with a registered tap select.
// Tap 0 is the input itself, tap k is k cycles old; output adds one register.
// Assumes sel never exceeds 2**DLY_W.
module fbc_delay #(
    parameter int unsigned DLY_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           d,
    input  logic [DLY_W:0] sel,
    output logic           q
);
    localparam int unsigned DEPTH = 1 << DLY_W;
    localparam int unsigned TAPS  = DEPTH + 1;

    logic [DEPTH-1:0] line;
    logic [TAPS-1:0]  taps;

    assign taps = {line, d};

    // Shift the conditioned level along the line.
    always_ff @(posedge clk) begin
        if (!rst_n) line <= '0;
        else        line <= {line[DEPTH-2:0], d};
    end

    // Register the selected tap as the aligned output.
    always_ff @(posedge clk) begin
        if (!rst_n)                 q <= 1'b0;
        else if (32'(sel) < TAPS)   q <= taps[sel];
        else                        q <= 1'b0;
    end
endmodule

// File: rtl/fblank_cond.sv
// Module: fast-blank input conditioner top level.
// Synchronizes the pin, applies the sense bit and delays the level. Holds
// sticky status and forwards the sub-cycle trim phase.
// Assumes a single clock domain for the register port and the video path.
module fblank_cond
    import fbc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DLY_W       = 4,
    parameter int unsigned TRIM_W      = 4,
    parameter int unsigned DLY_RST     = 4,
    parameter int unsigned TRIM_RST    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fb_pin,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              fb_out,
    output logic [2:0]        phase_out
);
    localparam int unsigned PH_W  = TRIM_W - 1;
    localparam int unsigned SEL_W = DLY_W + 1;

    logic              sense_q;
    logic [DLY_W-1:0]  dly_q;
    logic [TRIM_W-1:0] trim_q;
    logic              pin_s;
    logic              cond_w;
    logic              rd_clr;
    logic              rise_evt_w;
    fbc_stat_t         stat_s;
    logic [3:0]        stat_w;
    logic [SEL_W-1:0]  tap_sel;

    fbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d (fb_pin),
        .q (pin_s)
    );

    // Apply the programmed input sense.
    assign cond_w = pin_s ^ sense_q;

    assign rd_clr = rd_en && (addr == ADR_CTRL);

    fbc_status u_stat (
        .clk (clk),
        .rst_n (rst_n),
        .lvl (cond_w),
        .clr (rd_clr),
        .stat (stat_s),
        .rise_evt (rise_evt_w)
    );

    assign stat_w = stat_s;

    // Whole-cycle setting plus the carry from the trim's top bit.
    assign tap_sel = {1'b0, dly_q} + SEL_W'(trim_q[TRIM_W-1]);

    fbc_delay #(.DLY_W(DLY_W)) u_dly (
        .clk (clk),
        .rst_n (rst_n),
        .d (cond_w),
        .sel (tap_sel),
        .q (fb_out)
    );

    assign phase_out = 3'(trim_q[PH_W-1:0]);

    // Register writes for sense, delay and trim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= 1'b0;
            dly_q   <= DLY_W'(DLY_RST);
            trim_q  <= TRIM_W'(TRIM_RST);
        end else if (wr_en) begin
            case (addr)
                ADR_CTRL: sense_q <= wr_data[SENSE_BIT];
                ADR_DLY:  dly_q   <= wr_data[DLY_W-1:0];
                ADR_TRIM: trim_q  <= wr_data[TRIM_W-1:0];
                default:  ;
            endcase
        end
    end

    // Registered read mux; the sense bit is not readable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (addr)
                ADR_CTRL: rd_data <= {stat_w, 4'b0000};
                ADR_DLY:  rd_data <= 8'(dly_q);
                ADR_TRIM: rd_data <= 8'(trim_q);
                default:  rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/fblank_cond_chk.sv
// Module: property checker for the fast-blank conditioner, bound to the top.
// Assumes default reset values of 4 for delay and trim.
module fblank_cond_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [2:0] phase_out,
    input logic       cond_w,
    input logic [3:0] dly_q,
    input logic [3:0] stat_w,
    input logic       rise_evt_w
);
    logic rd_stat;
    assign rd_stat = rd_en && (addr == 2'd0);

    assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dly_q == 4'd4 && phase_out == 3'd4 && stat_w[0] == 1'b0
                          && stat_w[1] == 1'b0 && stat_w[3] == 1'b0));

    assert_delay_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> dly_q == $past(wr_data[3:0]));

    assert_phase_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2) |=> phase_out == $past(wr_data[2:0]));

    assert_live_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> rd_data[6] == $past(cond_w));

    assert_low_nibble_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> rd_data[3:0] == 4'd0);

    assert_keep_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && rise_evt_w) |=> stat_w[0]);

    assert_clear_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !rise_evt_w) |=> !stat_w[0]);

    assert_pre_clear_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> rd_data[4] == $past(stat_w[0]));
endmodule

bind fblank_cond fblank_cond_chk u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .phase_out (phase_out),
    .cond_w (cond_w),
    .dly_q (dly_q),
    .stat_w (stat_w),
    .rise_evt_w (rise_evt_w)
);

// File: tb/sim_fblank_cond.sv
// Bench: directed corner cases plus seeded random alignment trials.
module sim_fblank_cond;
    localparam int CLK_P = 10;
    localparam int HN    = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fb_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       fb_out;
    logic [2:0] phase_out;

    int   checks = 0;
    int   failures = 0;
    int   cyc = 0;
    bit   rand_on = 1'b0;
    bit   done = 1'b0;
    logic hist [HN];

    fblank_cond u0 (
        .clk (clk), .rst_n (rst_n), .fb_pin (fb_pin), .wr_en (wr_en),
        .rd_en (rd_en), .addr (addr), .wr_data (wr_data), .rd_data (rd_data),
        .fb_out (fb_out), .phase_out (phase_out)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Advance to the next falling edge, drive random pin if enabled, log it.
    task automatic tick();
        @(negedge clk);
        if (rand_on) fb_pin = 1'($urandom_range(0, 1));
        hist[(cyc + 1) % HN] = fb_pin;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        tick(); wr_en = 1'b1; addr = a; wr_data = d;
        tick(); wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        tick(); rd_en = 1'b1; addr = a;
        tick(); rd_en = 1'b0; v = rd_data;
    endtask

    // Expected aligned output for the edge count n.
    function automatic logic exp_out(int n, logic s, int tot);
        return s ^ hist[(n - 2 - tot + HN) % HN];
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < HN; i++) hist[i] = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: defaults
        check("R1 fb_out", fb_out, 0);
        check("R1 phase", phase_out, 4);
        rd(2'd1, v); check("R1 delay", v, 8'h04);
        rd(2'd2, v); check("R1 trim", v, 8'h04);
        rd(2'd0, v); check("R1 status", v, 8'h00);

        // R2: inverted sense with pin low gives a rising conditioned level
        wr(2'd0, 8'h08);
        repeat (30) tick();
        check("R2 fb_out inverted", fb_out, 1);
        rd(2'd0, v); check("R2 R5 R12 status", v, 8'hD0);
        wr(2'd0, 8'h00);
        repeat (30) tick();
        check("R2 fb_out normal", fb_out, 0);
        rd(2'd0, v); check("R6 status after sense back", v, 8'hA0);
        rd(2'd0, v); check("R9 cleared", v, 8'h00);

        // R5 R7 R8 R9: pin high
        fb_pin = 1'b1;
        repeat (6) tick();
        rd(2'd1, v); check("R9 other address read", v, 8'h04);
        rd(2'd0, v); check("R5 R7 R8 rise seen", v, 8'hD0);
        rd(2'd0, v); check("R9 R8 after clear", v, 8'hC0);
        fb_pin = 1'b0;
        repeat (6) tick();
        rd(2'd0, v); check("R6 fall seen", v, 8'hA0);
        rd(2'd0, v); check("R9 all clear", v, 8'h00);

        // R10: rise flag capture on the same edge as the clearing read
        tick(); fb_pin = 1'b1;
        tick();
        tick(); rd_en = 1'b1; addr = 2'd0;
        tick(); rd_en = 1'b0; v = rd_data;
        check("R10 pre-clear value", v, 8'h40);
        rd(2'd0, v); check("R10 event kept", v, 8'hD0);
        fb_pin = 1'b0;
        repeat (6) tick();
        rd(2'd0, v);
        rd(2'd0, v); check("R9 idle after R10", v, 8'h00);

        // R3 R4 R11: random alignment trials with corner settings first
        for (int t = 0; t < 10; t++) begin
            int d, tr, tot;
            logic s;
            d  = (t == 0) ? 0 : (t == 1) ? 15 : int'($urandom_range(0, 15));
            tr = (t == 0) ? 0 : (t == 1) ? 15 : int'($urandom_range(0, 15));
            s  = (t < 2) ? 1'b0 : 1'($urandom_range(0, 1));
            tot = d + (tr >> 3);
            rand_on = 1'b1;
            wr(2'd1, 8'(d));
            wr(2'd2, 8'(tr));
            wr(2'd0, {4'd0, s, 3'd0});
            rd(2'd1, v); check("R4 delay readback", v, d);
            rd(2'd2, v); check("R4 trim readback", v, tr);
            check("R11 phase", phase_out, tr & 7);
            repeat (24) tick();
            for (int k = 0; k < 60; k++) begin
                tick();
                check("R3 aligned output", fb_out, exp_out(cyc, s, tot));
            end
        end
        rand_on = 1'b0;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule